// File: doc/BRIEF.md
# Single-Register I2C Control Slave

This block is a two-wire serial slave that gives a host processor access to one 8-bit register for one power-supply channel. The six upper bits of the register are control bits that the host writes. The two lower bits are diagnostic flags. These flags are not stored: they are taken live from two external inputs whenever a read byte is prepared. The register has no sub-address. After START, the address byte alone selects write or read, and a write carries exactly one data byte.

SCL and SDA are sampled on the system clock. Each line passes through a two-flop synchronizer and a one-sample glitch filter before START, STOP and clock edges are detected. The block pulls SDA low through an open-drain enable. Two address-select pins choose one of four bus addresses. An undervoltage-lockout input clears the register and silences the slave for as long as it is asserted.

Top module: `chanreg_i2c`

## Requirements
- R1: After reset, `ctrl` is 0 and `sda_oe` is 0.
- R2: The slave address is the seven bits 0001 0xy, where xy is `addr_sel[1:0]` (`addr_sel[1]` is the more significant bit). A matching address byte is acknowledged: SDA is held low during the ninth clock. A non-matching address byte is not acknowledged, and the data byte that follows leaves `ctrl` unchanged.
- R3: When the address byte's last bit (R/W) is 0, the next byte is received MSB first and acknowledged. Its bits 7..2 are stored as `ctrl[5:0]`, with bit 7 going to `ctrl[5]`. `ctrl` changes only while SCL is low.
- R4: Bits 1..0 of a written byte are discarded. They do not change `ctrl`, and they do not appear in a later read.
- R5: When R/W is 1, the slave returns `{ctrl[5:0], diag[1], diag[0]}` MSB first. The byte is captured when SCL falls at the end of the address acknowledge slot.
- R6: If the master acknowledges a read byte, a fresh copy is captured and sent, carrying the current flags. A NACK ends the read, and SDA is released.
- R7: While `uvlo` is 1, `ctrl` is cleared on the next clock, no byte is acknowledged, and `sda_oe` stays 0. A read after `uvlo` falls returns zero control bits.
- R8: A second data byte in the same write is neither acknowledged nor stored.
- R9: A START inside a transfer restarts address reception, and the new address byte is acknowledged.
- R10: A STOP releases SDA and abandons a partial byte without changing `ctrl`.
- R11: A one-clock pulse on SCL, or a one-clock low pulse on SDA while SCL is high, is filtered out. It does not shift a bit and does not create a START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain drive enable; 1 pulls SDA low |
| addr_sel | input | 2 | Low two bits of the slave address |
| uvlo | input | 1 | Supply lockout; clears register, silences slave |
| diag | input | 2 | Live flags: bit 1 thermal, bit 0 overload |
| ctrl | output | 6 | Stored control bits (register bits 7..2) |

## Verification
Every bus event reaches the sequencer five system clocks after the raw line changes: two synchronizer flops, two filter samples and the edge register. An acknowledge or a new read bit therefore appears on SDA five clocks after SCL falls, and `ctrl` takes a written byte on that same clock. The bench holds each SCL quarter-phase for ten clocks. It samples SDA in the middle of the high phase, at least twenty clocks after the preceding fall, and it reads `ctrl` only after STOP. The effect of `uvlo` is due one clock after it rises, and the bench checks it two clocks later.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_st_t;
endpackage

// File: rtl/chanreg_filt.sv
module chanreg_filt #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  logic [STAGES-1:0] chain;
  logic              s_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
      s_d   <= RST_VAL;
      filt  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], raw};
      s_d   <= chain[STAGES-1];
      if (chain[STAGES-1] == s_d) filt <= s_d;
    end
  end
endmodule

// File: rtl/chanreg_cfg.sv
module chanreg_cfg #(
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uvlo,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst || uvlo) ctrl_q <= '0;
    else if (wr_en)  ctrl_q <= wr_data;
  end
endmodule

// File: rtl/chanreg_fsm.sv
module chanreg_fsm
  import chanreg_pkg::*;
#(
  parameter int                CTRL_W  = 6,
  parameter int                FLAG_W  = 2,
  parameter int                SEL_W   = 2,
  parameter logic [6-SEL_W:0]  ADDR_HI = 5'b00010
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_f,
  input  logic                       sda_f,
  input  logic [SEL_W-1:0]           addr_sel,
  input  logic                       uvlo,
  input  logic [CTRL_W+FLAG_W-1:0]   reg_img,
  output logic                       wr_en,
  output logic [CTRL_W-1:0]          wr_data,
  output logic                       sda_oe
);
  localparam int BYTE_W = CTRL_W + FLAG_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  bus_st_t            st;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh;
  logic [BYTE_W-1:0]  tx;
  logic               scl_q, sda_q, mack;
  logic               scl_rise, scl_fall, start_ev, stop_ev;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  assign wr_en   = (st == ST_WDATA) && scl_fall && (cnt == LAST) && !uvlo;
  assign wr_data = sh[BYTE_W-1 -: CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (uvlo) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_f};
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == LAST) begin
              if (sh[BYTE_W-1:1] == {ADDR_HI, addr_sel}) begin
                sda_oe <= 1'b1;
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (sh[0]) begin
                tx     <= reg_img;
                sda_oe <= ~reg_img[BYTE_W-1];
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_f};
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == LAST) begin
              sda_oe <= 1'b1;
              st     <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_IDLE;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                sda_oe <= ~tx[BYTE_W-2];
                tx     <= tx << 1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_f;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                tx     <= reg_img;
                sda_oe <= ~reg_img[BYTE_W-1];
                st     <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chanreg_i2c.sv
module chanreg_i2c #(
  parameter int               CTRL_W      = 6,
  parameter int               FLAG_W      = 2,
  parameter int               SEL_W       = 2,
  parameter int               SYNC_STAGES = 2,
  parameter logic [6-SEL_W:0] ADDR_HI     = 5'b00010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              uvlo,
  input  logic [FLAG_W-1:0] diag,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int BYTE_W = CTRL_W + FLAG_W;

  logic [1:0]        line_raw;
  logic [1:0]        line_f;
  logic              wr_en;
  logic [CTRL_W-1:0] wr_data;
  logic [BYTE_W-1:0] reg_img;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    chanreg_filt #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (line_raw[g]),
      .filt(line_f[g])
    );
  end

  assign reg_img = {ctrl, diag};

  chanreg_fsm #(
    .CTRL_W (CTRL_W),
    .FLAG_W (FLAG_W),
    .SEL_W  (SEL_W),
    .ADDR_HI(ADDR_HI)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (line_f[0]),
    .sda_f   (line_f[1]),
    .addr_sel(addr_sel),
    .uvlo    (uvlo),
    .reg_img (reg_img),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sda_oe  (sda_oe)
  );

  chanreg_cfg #(.CTRL_W(CTRL_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .uvlo   (uvlo),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .ctrl_q (ctrl)
  );
endmodule

// File: rtl/chanreg_chk.sv
module chanreg_chk #(
  parameter int CTRL_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              uvlo,
  input logic              scl_f,
  input logic              sda_f,
  input logic              sda_oe,
  input logic [CTRL_W-1:0] ctrl_q
);
  logic scl_p, sda_p, stop_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign stop_c = scl_f && scl_p && !sda_p && sda_f;

  // R7
  uvlo_clear_chk: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> (ctrl_q == '0));

  // R7
  uvlo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> !sda_oe);

  // R2
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_q) |-> (!scl_f || $past(uvlo)));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe);
endmodule

bind chanreg_i2c chanreg_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .uvlo  (uvlo),
  .scl_f (line_f[0]),
  .sda_f (line_f[1]),
  .sda_oe(sda_oe),
  .ctrl_q(ctrl)
);

// File: tb/sim_chanreg_i2c.sv
module sim_chanreg_i2c;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [1:0] addr_sel = 2'b10;
  logic       uvlo = 1'b0;
  logic [1:0] diag = 2'b00;
  logic [5:0] ctrl;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  string lbl_q[$];
  int    exp_q[$];
  int    obs_q[$];

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  chanreg_i2c u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .uvlo(uvlo), .diag(diag), .ctrl(ctrl)
  );

  // driver side: expected item and the observed value enter the scoreboard
  task automatic score(input string lbl, input int exp, input int act);
    lbl_q.push_back(lbl);
    exp_q.push_back(exp);
    obs_q.push_back(act);
  endtask

  // monitor: pops and compares
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      string l;
      int e, a;
      l = lbl_q.pop_front();
      e = exp_q.pop_front();
      a = obs_q.pop_front();
      checks++;
      if (e != a) begin
        fails++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", l, a, e);
      end
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_bit(input logic b, input logic gscl, input logic gsda);
    sda_m = b;
    if (gscl) begin
      repeat (4) @(negedge clk);
      scl_m = 1'b1;
      @(negedge clk);
      scl_m = 1'b0;
      repeat (Q - 5) @(negedge clk);
    end else wait_q();
    scl_m = 1'b1;
    wait_q();
    if (gsda) begin
      sda_m = 1'b0;
      @(negedge clk);
      sda_m = b;
      repeat (Q - 1) @(negedge clk);
    end else wait_q();
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [7:0] gscl,
                           input logic [7:0] gsda, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], gscl[i], gsda[i]);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    ack = ~sda_bus;
    wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      b[i] = sda_bus;
      wait_q();
      scl_m = 1'b0; wait_q();
    end
  endtask

  task automatic master_ack(input logic ack);
    sda_m = ~ack; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic write_txn(input string tag, input logic [7:0] adr, input logic [7:0] dat,
                           input int exp_aack, input int exp_dack, input int exp_ctrl);
    logic a;
    bus_start();
    send_byte(adr, 8'h00, 8'h00, a);
    score({tag, " address ack"}, exp_aack, int'(a));
    send_byte(dat, 8'h00, 8'h00, a);
    score({tag, " data ack"}, exp_dack, int'(a));
    bus_stop();
    wait_q();
    score({tag, " ctrl"}, exp_ctrl, int'(ctrl));
  endtask

  task automatic read_txn(input string tag, input logic [7:0] adr, input int exp_byte);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(adr, 8'h00, 8'h00, a);
    score({tag, " address ack"}, 1, int'(a));
    recv_byte(d);
    score({tag, " read byte"}, exp_byte, int'(d));
    master_ack(1'b0);
    bus_stop();
    wait_q();
    score({tag, " sda released"}, 0, int'(sda_oe));
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    score("R1 ctrl after reset", 0, int'(ctrl));
    score("R1 sda_oe after reset", 0, int'(sda_oe));

    // R2/R3: addr_sel=10 -> address 0001010, write 0xA5 -> ctrl 101001
    write_txn("R3 write", 8'h14, 8'hA5, 1, 1, 6'h29);
    // R4: read-only bits set in written byte are discarded
    write_txn("R4 write ro bits", 8'h14, 8'hA7, 1, 1, 6'h29);
    read_txn("R4 readback", 8'h15, 8'hA4);

    // R5/R6: read with flags 10, then continued read with new flags 01
    diag = 2'b10;
    bus_start();
    send_byte(8'h15, 8'h00, 8'h00, a);
    score("R2 read address ack", 1, int'(a));
    recv_byte(d);
    score("R5 first read byte", 8'hA6, int'(d));
    diag = 2'b01;
    master_ack(1'b1);
    recv_byte(d);
    score("R6 second copy after master ack", 8'hA5, int'(d));
    master_ack(1'b0);
    wait_q();
    score("R6 released after nack", 0, int'(sda_oe));
    bus_stop();

    // R2: mismatching address ignored
    write_txn("R2 wrong address", 8'h10, 8'hFC, 0, 0, 6'h29);

    // R8: second data byte refused
    bus_start();
    send_byte(8'h14, 8'h00, 8'h00, a);
    send_byte(8'h5A, 8'h00, 8'h00, a);
    score("R8 first data ack", 1, int'(a));
    send_byte(8'hFF, 8'h00, 8'h00, a);
    score("R8 second data nack", 0, int'(a));
    bus_stop();
    wait_q();
    score("R8 ctrl keeps first byte", 6'h16, int'(ctrl));

    // R9: repeated start mid data byte
    bus_start();
    send_byte(8'h14, 8'h00, 8'h00, a);
    send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    bus_start();
    send_byte(8'h15, 8'h00, 8'h00, a);
    score("R9 address ack after restart", 1, int'(a));
    recv_byte(d);
    score("R9 read after restart", 8'h59, int'(d));
    master_ack(1'b0);
    bus_stop();

    // R10: stop inside a data byte
    bus_start();
    send_byte(8'h14, 8'h00, 8'h00, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0, 1'b0);
    bus_stop();
    wait_q();
    score("R10 ctrl unchanged by partial byte", 6'h16, int'(ctrl));
    score("R10 sda released", 0, int'(sda_oe));

    // R11: glitches filtered; addr_sel=11 -> address 0001011
    addr_sel = 2'b11;
    bus_start();
    send_byte(8'h16, 8'h04, 8'h00, a);
    score("R11 address ack with scl glitch", 1, int'(a));
    send_byte(8'hCC, 8'h10, 8'h80, a);
    score("R11 data ack with glitches", 1, int'(a));
    bus_stop();
    wait_q();
    score("R11 ctrl after glitches", 6'h33, int'(ctrl));

    // R7: lockout
    uvlo = 1'b1;
    repeat (2) @(negedge clk);
    score("R7 ctrl cleared", 0, int'(ctrl));
    bus_start();
    send_byte(8'h16, 8'h00, 8'h00, a);
    score("R7 no ack under lockout", 0, int'(a));
    bus_stop();
    uvlo = 1'b0;
    wait_q();
    score("R7 ctrl stays zero", 0, int'(ctrl));
    read_txn("R7 read after lockout", 8'h17, 8'h01);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule